// File: doc/BRIEF.md
# Tiled Large-Kernel Convolution Engine

This block computes a single-channel two-dimensional valid convolution of a small stored image with a square filter whose side can be anything from one up to a configured maximum (eleven by default). It has only one three-by-three multiply-accumulate unit. The filter is treated as if zero weights were appended on its bottom and right edges until its side is a multiple of three. That extended filter is then cut into three-by-three tiles. Each tile is anchored at the row and column of its top-left weight, and that anchor is the tile's shift offset. Every tile is swept over all output positions on its own. Each partial result is added into an on-chip output buffer at the output position, with the tile's shift offset applied to the image window it reads.

Before a run, the image and the filter are written through a single load port. A start pulse with a kernel size launches the run. The engine then produces one three-by-three partial sum per cycle. It visits the tiles in row-major order of their offsets, and within each tile it visits the output pixels in row-major order. A one-cycle done pulse marks the point where every partial sum has been accumulated. The result stays readable through a combinational read port until the next accepted start.

Top module: `cdk_conv_engine`

## Requirements
- R1: A start pulse is accepted only while busy is low and only when 1 <= ksize <= KMAX, ksize <= IMG_H and ksize <= IMG_W. An accepted start raises busy at the next clock edge. A start with any other ksize leaves busy low and leaves the output buffer unchanged.
- R2: An accepted start clears the whole output buffer to zero. After a run, every position outside the (IMG_H-K+1) x (IMG_W-K+1) output region reads zero.
- R3: The load port writes the image when ld_sel = 0 and the filter when ld_sel = 1, at (ld_row, ld_col). After a run with kernel size K, output (x,y) equals the sum over i,j < K of image[x+i][y+j] * filter[i][j]. Image and filter values are 8-bit two's complement and the result is 24-bit two's complement.
- R4: Stored filter weights at a row or column >= K act as zero weights, so stale weights left over from a larger filter have no effect on the result.
- R5: A start pulse while busy is ignored. The run continues with its original kernel size and completes with the same latency and the same result.
- R6: done is high for exactly one cycle. busy falls at the same edge where done rises. done rises at edge N + MAC_PIPE after the edge that accepted start, where N = ceil(K/3)^2 * (IMG_H-K+1) * (IMG_W-K+1).
- R7: rd_data shows the buffer entry at (rd_row, rd_col) combinationally. A coordinate at or beyond IMG_H or IMG_W reads zero. The result holds until the next accepted start.
- R8: After reset, busy and done are low and every buffer position reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 1 | 0 = image, 1 = filter |
| ld_row | input | CW | Load row |
| ld_col | input | CW | Load column |
| ld_data | input | DW | Signed value to store |
| start | input | 1 | Run request pulse |
| ksize | input | KW | Filter side K |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_row | input | CW | Output read row |
| rd_col | input | CW | Output read column |
| rd_data | output | ACCW | Signed accumulated output |

## Verification
On every cycle, the assertions check the start handshake: acceptance and rejection by kernel size, and busy holding the latched kernel size. They also check that done is a single-cycle pulse that ends busy, and that every accumulation lands inside the output region and never happens while idle. Only the bench's scenarios can show the arithmetic. It sweeps every kernel size from 1 to 11 and compares each accumulated value with a direct KxK convolution, and it also covers extreme operand values, the zeroing of stale weights, the exact completion latency and the clearing between runs.

// File: rtl/cdk_pkg.sv
package cdk_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RUN  = 2'd1,
      SEQ_WAIT = 2'd2
   } seq_state_e;

   localparam int TAP_SIDE = 3;
   localparam int TAP_NUM  = TAP_SIDE * TAP_SIDE;
endpackage

// File: rtl/cdk_operand_store.sv
module cdk_operand_store #(
   parameter int IMG_H = 12,
   parameter int IMG_W = 12,
   parameter int KMAX  = 11,
   parameter int DW    = 8,
   parameter int CW    = 4,
   parameter int KW    = 4,
   parameter int PW    = 6
) (
   input  logic                 clk,
   input  logic                 ld_en,
   input  logic                 ld_sel,
   input  logic [CW-1:0]        ld_row,
   input  logic [CW-1:0]        ld_col,
   input  logic [DW-1:0]        ld_data,
   input  logic [CW-1:0]        orow_i,
   input  logic [CW-1:0]        ocol_i,
   input  logic [PW-1:0]        trow_i,
   input  logic [PW-1:0]        tcol_i,
   input  logic [KW-1:0]        k_i,
   output logic signed [DW-1:0] pix_o [cdk_pkg::TAP_NUM],
   output logic signed [DW-1:0] wgt_o [cdk_pkg::TAP_NUM]
);
   localparam int NPOS = 2 ** CW;

   logic signed [DW-1:0] img_q [NPOS][NPOS];
   logic signed [DW-1:0] flt_q [NPOS][NPOS];

   logic img_wr, flt_wr;
   assign img_wr = ld_en && !ld_sel && (ld_row < CW'(IMG_H)) && (ld_col < CW'(IMG_W));
   assign flt_wr = ld_en &&  ld_sel && (ld_row < CW'(KMAX))  && (ld_col < CW'(KMAX));

   always_ff @(posedge clk) begin
      if (img_wr) img_q[ld_row][ld_col] <= ld_data;
      if (flt_wr) flt_q[ld_row][ld_col] <= ld_data;
   end

   for (genvar i = 0; i < cdk_pkg::TAP_SIDE; i++) begin : g_row
      for (genvar j = 0; j < cdk_pkg::TAP_SIDE; j++) begin : g_col
         localparam int T = i * cdk_pkg::TAP_SIDE + j;
         logic [PW-1:0] wr, wc, pr, pc;
         logic          in_img, in_flt;
         assign wr     = trow_i + PW'(i);
         assign wc     = tcol_i + PW'(j);
         assign pr     = PW'(orow_i) + wr;
         assign pc     = PW'(ocol_i) + wc;
         assign in_img = (pr < PW'(IMG_H)) && (pc < PW'(IMG_W));
         assign in_flt = (wr < PW'(k_i)) && (wc < PW'(k_i));
         assign pix_o[T] = in_img ? img_q[pr[CW-1:0]][pc[CW-1:0]] : '0;
         assign wgt_o[T] = in_flt ? flt_q[wr[CW-1:0]][wc[CW-1:0]] : '0;
      end
   end
endmodule

// File: rtl/cdk_tile_seq.sv
module cdk_tile_seq #(
   parameter int IMG_H = 12,
   parameter int IMG_W = 12,
   parameter int KMAX  = 11,
   parameter int CW    = 4,
   parameter int KW    = 4,
   parameter int PW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept_i,
   input  logic [KW-1:0] ksize_i,
   input  logic          fin_i,
   output logic          busy_o,
   output logic          iss_valid_o,
   output logic          iss_last_o,
   output logic [CW-1:0] iss_orow_o,
   output logic [CW-1:0] iss_ocol_o,
   output logic [PW-1:0] iss_trow_o,
   output logic [PW-1:0] iss_tcol_o,
   output logic [KW-1:0] k_o,
   output logic [CW-1:0] oh_o,
   output logic [CW-1:0] ow_o
);
   import cdk_pkg::*;

   seq_state_e    state_q;
   logic [KW-1:0] k_q, tiles_q, ta_q, tb_q;
   logic [CW-1:0] oh_q, ow_q, x_q, y_q;
   logic [KW:0]   kp2;
   logic          y_end, x_end, tb_end, ta_end;

   assign kp2    = {1'b0, ksize_i} + (KW+1)'(2);
   assign y_end  = (y_q  == ow_q - CW'(1));
   assign x_end  = (x_q  == oh_q - CW'(1));
   assign tb_end = (tb_q == tiles_q - KW'(1));
   assign ta_end = (ta_q == tiles_q - KW'(1));

   assign busy_o      = (state_q != SEQ_IDLE);
   assign iss_valid_o = (state_q == SEQ_RUN);
   assign iss_last_o  = y_end && x_end && tb_end && ta_end;
   assign iss_orow_o  = x_q;
   assign iss_ocol_o  = y_q;
   assign iss_trow_o  = PW'(ta_q) * PW'(TAP_SIDE);
   assign iss_tcol_o  = PW'(tb_q) * PW'(TAP_SIDE);
   assign k_o         = k_q;
   assign oh_o        = oh_q;
   assign ow_o        = ow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         k_q     <= '0;
         tiles_q <= '0;
         oh_q    <= '0;
         ow_q    <= '0;
         ta_q    <= '0;
         tb_q    <= '0;
         x_q     <= '0;
         y_q     <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (accept_i) begin
                  state_q <= SEQ_RUN;
                  k_q     <= ksize_i;
                  tiles_q <= KW'(kp2 / (KW+1)'(TAP_SIDE));
                  oh_q    <= CW'(IMG_H) - CW'(ksize_i) + CW'(1);
                  ow_q    <= CW'(IMG_W) - CW'(ksize_i) + CW'(1);
                  ta_q    <= '0;
                  tb_q    <= '0;
                  x_q     <= '0;
                  y_q     <= '0;
               end
            end
            SEQ_RUN: begin
               if (iss_last_o) begin
                  state_q <= fin_i ? SEQ_IDLE : SEQ_WAIT;
               end
               if (!y_end) begin
                  y_q <= y_q + CW'(1);
               end else begin
                  y_q <= '0;
                  if (!x_end) begin
                     x_q <= x_q + CW'(1);
                  end else begin
                     x_q <= '0;
                     if (!tb_end) begin
                        tb_q <= tb_q + KW'(1);
                     end else begin
                        tb_q <= '0;
                        if (!ta_end) ta_q <= ta_q + KW'(1);
                        else         ta_q <= '0;
                     end
                  end
               end
            end
            SEQ_WAIT: begin
               if (fin_i) state_q <= SEQ_IDLE;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cdk_mac3x3.sv
module cdk_mac3x3 #(
   parameter int DW       = 8,
   parameter int ACCW     = 24,
   parameter int CW       = 4,
   parameter int MAC_PIPE = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic                   in_last,
   input  logic [CW-1:0]          in_row,
   input  logic [CW-1:0]          in_col,
   input  logic signed [DW-1:0]   pix_i [cdk_pkg::TAP_NUM],
   input  logic signed [DW-1:0]   wgt_i [cdk_pkg::TAP_NUM],
   output logic                   out_valid,
   output logic                   out_last,
   output logic [CW-1:0]          out_row,
   output logic [CW-1:0]          out_col,
   output logic signed [ACCW-1:0] out_sum
);
   logic signed [ACCW-1:0] sum_c;

   always_comb begin
      sum_c = '0;
      for (int t = 0; t < cdk_pkg::TAP_NUM; t++) begin
         logic signed [ACCW-1:0] pe, we;
         pe    = ACCW'(pix_i[t]);
         we    = ACCW'(wgt_i[t]);
         sum_c = sum_c + pe * we;
      end
   end

   if (MAC_PIPE != 0) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_row   <= '0;
            out_col   <= '0;
            out_sum   <= '0;
         end else begin
            out_valid <= in_valid;
            out_last  <= in_valid && in_last;
            out_row   <= in_row;
            out_col   <= in_col;
            out_sum   <= sum_c;
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign out_last  = in_valid && in_last;
      assign out_row   = in_row;
      assign out_col   = in_col;
      assign out_sum   = sum_c;
   end
endmodule

// File: rtl/cdk_acc_buffer.sv
module cdk_acc_buffer #(
   parameter int IMG_H = 12,
   parameter int IMG_W = 12,
   parameter int ACCW  = 24,
   parameter int CW    = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear_i,
   input  logic                   wr_valid,
   input  logic [CW-1:0]          wr_row,
   input  logic [CW-1:0]          wr_col,
   input  logic signed [ACCW-1:0] wr_val,
   input  logic [CW-1:0]          rd_row,
   input  logic [CW-1:0]          rd_col,
   output logic signed [ACCW-1:0] rd_data
);
   localparam int NPOS = 2 ** CW;

   logic signed [ACCW-1:0] acc_q [NPOS][NPOS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NPOS; r++)
            for (int c = 0; c < NPOS; c++)
               acc_q[r][c] <= '0;
      end else if (clear_i) begin
         for (int r = 0; r < NPOS; r++)
            for (int c = 0; c < NPOS; c++)
               acc_q[r][c] <= '0;
      end else if (wr_valid) begin
         acc_q[wr_row][wr_col] <= acc_q[wr_row][wr_col] + wr_val;
      end
   end

   assign rd_data = ((rd_row < CW'(IMG_H)) && (rd_col < CW'(IMG_W)))
                    ? acc_q[rd_row][rd_col] : '0;
endmodule

// File: rtl/cdk_conv_engine.sv
module cdk_conv_engine #(
   parameter int IMG_H    = 12,
   parameter int IMG_W    = 12,
   parameter int KMAX     = 11,
   parameter int DW       = 8,
   parameter int ACCW     = 24,
   parameter int MAC_PIPE = 1,
   localparam int MAXD    = (IMG_H > IMG_W) ? ((IMG_H > KMAX) ? IMG_H : KMAX)
                                            : ((IMG_W > KMAX) ? IMG_W : KMAX),
   localparam int CW      = $clog2(MAXD + 1),
   localparam int KW      = $clog2(KMAX + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ld_en,
   input  logic                   ld_sel,
   input  logic [CW-1:0]          ld_row,
   input  logic [CW-1:0]          ld_col,
   input  logic [DW-1:0]          ld_data,
   input  logic                   start,
   input  logic [KW-1:0]          ksize,
   output logic                   busy,
   output logic                   done,
   input  logic [CW-1:0]          rd_row,
   input  logic [CW-1:0]          rd_col,
   output logic signed [ACCW-1:0] rd_data
);
   localparam int PW = CW + 2;
   localparam int NT = (KMAX + 2) / 3;

   if (IMG_H < 1 || IMG_W < 1 || KMAX < 1) begin : g_bad_dims
      $error("cdk_conv_engine: image and kernel sizes must be positive");
   end
   if (DW < 2) begin : g_bad_dw
      $error("cdk_conv_engine: DW must be at least 2");
   end
   if (ACCW < 2 * DW + $clog2(NT * NT * 9 + 1)) begin : g_bad_accw
      $error("cdk_conv_engine: ACCW too narrow for worst-case sum");
   end
   if (MAC_PIPE != 0 && MAC_PIPE != 1) begin : g_bad_pipe
      $error("cdk_conv_engine: MAC_PIPE must be 0 or 1");
   end

   logic          ksize_ok, accept;
   logic          iss_valid, iss_last;
   logic [CW-1:0] iss_orow, iss_ocol;
   logic [PW-1:0] iss_trow, iss_tcol;
   logic [KW-1:0] k_q;
   logic [CW-1:0] oh_q, ow_q;
   logic          mac_valid, mac_last;
   logic [CW-1:0] mac_row, mac_col;
   logic signed [ACCW-1:0] mac_sum;
   logic signed [DW-1:0]   pix [cdk_pkg::TAP_NUM];
   logic signed [DW-1:0]   wgt [cdk_pkg::TAP_NUM];
   logic          done_q;

   assign ksize_ok = (ksize != '0) && (int'(ksize) <= KMAX)
                  && (int'(ksize) <= IMG_H) && (int'(ksize) <= IMG_W);
   assign accept   = start && !busy && ksize_ok;

   cdk_tile_seq #(.IMG_H(IMG_H), .IMG_W(IMG_W), .KMAX(KMAX),
                  .CW(CW), .KW(KW), .PW(PW)) seq_i (
      .clk(clk), .rst_n(rst_n), .accept_i(accept), .ksize_i(ksize),
      .fin_i(mac_last), .busy_o(busy), .iss_valid_o(iss_valid),
      .iss_last_o(iss_last), .iss_orow_o(iss_orow), .iss_ocol_o(iss_ocol),
      .iss_trow_o(iss_trow), .iss_tcol_o(iss_tcol), .k_o(k_q),
      .oh_o(oh_q), .ow_o(ow_q)
   );

   cdk_operand_store #(.IMG_H(IMG_H), .IMG_W(IMG_W), .KMAX(KMAX), .DW(DW),
                       .CW(CW), .KW(KW), .PW(PW)) store_i (
      .clk(clk), .ld_en(ld_en), .ld_sel(ld_sel), .ld_row(ld_row),
      .ld_col(ld_col), .ld_data(ld_data), .orow_i(iss_orow),
      .ocol_i(iss_ocol), .trow_i(iss_trow), .tcol_i(iss_tcol), .k_i(k_q),
      .pix_o(pix), .wgt_o(wgt)
   );

   cdk_mac3x3 #(.DW(DW), .ACCW(ACCW), .CW(CW), .MAC_PIPE(MAC_PIPE)) mac_i (
      .clk(clk), .rst_n(rst_n), .in_valid(iss_valid), .in_last(iss_last),
      .in_row(iss_orow), .in_col(iss_ocol), .pix_i(pix), .wgt_i(wgt),
      .out_valid(mac_valid), .out_last(mac_last), .out_row(mac_row),
      .out_col(mac_col), .out_sum(mac_sum)
   );

   cdk_acc_buffer #(.IMG_H(IMG_H), .IMG_W(IMG_W), .ACCW(ACCW), .CW(CW)) buf_i (
      .clk(clk), .rst_n(rst_n), .clear_i(accept), .wr_valid(mac_valid),
      .wr_row(mac_row), .wr_col(mac_col), .wr_val(mac_sum),
      .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= mac_last;
   end
   assign done = done_q;
endmodule

// File: rtl/cdk_conv_engine_chk.sv
module cdk_conv_engine_chk #(
   parameter int IMG_H = 12,
   parameter int IMG_W = 12,
   parameter int KMAX  = 11,
   parameter int CW    = 4,
   parameter int KW    = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [KW-1:0] ksize,
   input logic          busy,
   input logic          done,
   input logic          acc_valid,
   input logic [CW-1:0] acc_row,
   input logic [CW-1:0] acc_col,
   input logic [CW-1:0] oh,
   input logic [CW-1:0] ow,
   input logic [KW-1:0] k_q
);
   logic size_legal;
   assign size_legal = (int'(ksize) >= 1) && (int'(ksize) <= KMAX)
                    && (int'(ksize) <= IMG_H) && (int'(ksize) <= IMG_W);

   p_start_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && size_legal) |=> busy);
   p_start_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && !size_legal) |=> !busy);
   p_idle_no_acc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !acc_valid);
   p_acc_in_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> (acc_row < oh) && (acc_col < ow));
   p_ksize_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(k_q));
   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
endmodule

bind cdk_conv_engine cdk_conv_engine_chk #(
   .IMG_H(IMG_H), .IMG_W(IMG_W), .KMAX(KMAX), .CW(CW), .KW(KW)
) chk_i (
   .clk(clk), .rst_n(rst_n), .start(start), .ksize(ksize), .busy(busy),
   .done(done), .acc_valid(mac_valid), .acc_row(mac_row), .acc_col(mac_col),
   .oh(oh_q), .ow(ow_q), .k_q(k_q)
);

// File: tb/cdk_conv_engine_tb_top.sv
module cdk_conv_engine_tb_top;
   localparam int H = 12, W = 12, KM = 11, DW = 8, AW = 24, PIPE = 1;
   localparam int CW = 4, KW = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, ld_en, ld_sel, start, busy, done;
   logic [CW-1:0] ld_row, ld_col, rd_row, rd_col;
   logic [DW-1:0] ld_data;
   logic [KW-1:0] ksize;
   logic signed [AW-1:0] rd_data;

   cdk_conv_engine #(.IMG_H(H), .IMG_W(W), .KMAX(KM), .DW(DW), .ACCW(AW),
                     .MAC_PIPE(PIPE)) dut_i (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
      .ld_row(ld_row), .ld_col(ld_col), .ld_data(ld_data), .start(start),
      .ksize(ksize), .busy(busy), .done(done), .rd_row(rd_row),
      .rd_col(rd_col), .rd_data(rd_data)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   int img [H][W];
   int flt [KM][KM];

   task automatic check(string tag, longint act, longint exp, string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic read_out(int r, int c, output int v);
      @(negedge clk);
      rd_row = CW'(r);
      rd_col = CW'(c);
      #1;
      v = int'(rd_data);
   endtask

   // mode 0: random, 1: image -128 filter -128, 2: image 127 filter -128
   task automatic load_data(int mode);
      for (int r = 0; r < H; r++)
         for (int c = 0; c < W; c++)
            img[r][c] = (mode == 0) ? int'($urandom % 256) - 128 : (mode == 1 ? -128 : 127);
      for (int r = 0; r < KM; r++)
         for (int c = 0; c < KM; c++)
            flt[r][c] = (mode == 0) ? int'($urandom % 256) - 128 : -128;
      for (int r = 0; r < H; r++)
         for (int c = 0; c < W; c++) begin
            @(negedge clk);
            ld_en = 1; ld_sel = 0; ld_row = CW'(r); ld_col = CW'(c);
            ld_data = DW'(img[r][c]);
         end
      for (int r = 0; r < KM; r++)
         for (int c = 0; c < KM; c++) begin
            @(negedge clk);
            ld_en = 1; ld_sel = 1; ld_row = CW'(r); ld_col = CW'(c);
            ld_data = DW'(flt[r][c]);
         end
      @(negedge clk);
      ld_en = 0;
   endtask

   function automatic int ref_out(int k, int x, int y);
      int s = 0;
      if (x > H - k || y > W - k) return 0;
      for (int i = 0; i < k; i++)
         for (int j = 0; j < k; j++)
            s += img[x+i][y+j] * flt[i][j];
      return s;
   endfunction

   task automatic run_conv(int k, bit inject);
      int cyc = 0;
      int tiles = (k + 2) / 3;
      int n_exp = tiles * tiles * (H - k + 1) * (W - k + 1);
      @(negedge clk);
      start = 1; ksize = KW'(k);
      @(posedge clk);
      @(negedge clk);
      start = 0;
      check("R1", busy, 1, $sformatf("busy after accepted start k=%0d", k));
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         start = 0;
         if (inject && cyc == 5) begin
            start = 1; ksize = KW'(3);
         end
      end
      start = 0;
      check(inject ? "R5" : "R6", cyc, n_exp + PIPE,
            $sformatf("done latency k=%0d", k));
      check("R6", busy, 0, "busy low when done high");
      @(negedge clk);
      check("R6", done, 0, "done lasts one cycle");
   endtask

   task automatic verify(int k, string tag);
      int v;
      for (int r = 0; r < H; r++)
         for (int c = 0; c < W; c++) begin
            read_out(r, c, v);
            check((r > H - k || c > W - k) ? "R2" : tag, v, ref_out(k, r, c),
                  $sformatf("out[%0d][%0d] k=%0d", r, c, k));
         end
      read_out(H, 0, v);
      check("R7", v, 0, "row beyond image reads zero");
      read_out(0, W + 2, v);
      check("R7", v, 0, "col beyond image reads zero");
   endtask

   initial begin
      #(8 * 190000);
      if (!finished) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int v, held;
      rst_n = 0; ld_en = 0; ld_sel = 0; ld_row = '0; ld_col = '0;
      ld_data = '0; start = 0; ksize = '0; rd_row = '0; rd_col = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      check("R8", busy, 0, "busy after reset");
      check("R8", done, 0, "done after reset");
      read_out(0, 0, v);
      check("R8", v, 0, "buffer (0,0) after reset");
      read_out(7, 5, v);
      check("R8", v, 0, "buffer (7,5) after reset");

      for (int k = 1; k <= KM; k++) begin
         load_data(0);
         run_conv(k, 0);
         verify(k, (k < KM) ? "R4" : "R3");
      end

      load_data(1);
      run_conv(11, 0);
      verify(11, "R3");
      load_data(2);
      run_conv(7, 0);
      verify(7, "R3");

      read_out(0, 0, held);
      @(negedge clk);
      start = 1; ksize = KW'(0);
      @(negedge clk);
      start = 0;
      check("R1", busy, 0, "ksize 0 rejected");
      @(negedge clk);
      start = 1; ksize = KW'(12);
      @(negedge clk);
      start = 0;
      check("R1", busy, 0, "ksize 12 rejected");
      read_out(0, 0, v);
      check("R1", v, held, "buffer kept after rejected start");
      check("R7", v, ref_out(7, 0, 0), "result held until next start");

      load_data(0);
      run_conv(5, 1);
      verify(5, "R5");

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule